// File: doc/BRIEF.md
# Reset-Synchronized Three-Phase PWM Timer

This block is a 16-bit up-counting timer that produces three complementary pairs of PWM outputs, for example for brushless DC motor drive. The counter counts up from zero. It returns to zero on the strobe at which it equals the period register, so the period register sets the PWM cycle. Three compare registers, one per phase, set the point in the cycle at which each phase becomes active. Each phase drives a positive pin and a negative pin, and the negative pin is the complement of the positive pin. The positive pins and the negative pins each have their own polarity bit. Each of the six pins has its own enable bit. A toggle output can be enabled to invert once per PWM cycle.

Software sets up the block through a simple write port. The mode, period, compare and polarity registers accept writes only while the run bit is clear, and the counter can be loaded only while halted. The counter advances only on a count strobe. This strobe comes from a free-running prescaler, which has a divide select and an edge select.

Top module: `rsync_pwm3`

## Requirements
- R1: After reset the counter, every register and every enable are zero. All six PWM pins and the toggle output are then 0, which is the inactive level for polarity 0.
- R2: While running, each count strobe raises the counter by one. On a strobe at which the counter equals the period register (address 2) it goes to zero instead.
- R3: Writes to mode (1), period (2), compare 0..2 (3..5), polarity (6) and counter load (9) take effect only while the run bit is 0. While the run bit is 1 they are ignored. Run (address 0, bit 0), enables (7) and clock select (8) can always be written.
- R4: PWM operation is selected by the value 4'b1000 in mode bits [3:0]. Any other value puts all six pins at their inactive level.
- R5: On a strobe at which the counter equals compare i, phase i becomes active. On a strobe at which the counter equals the period without a match, phase i becomes inactive. If both happen on the same strobe, the match wins. A compare value above the period never matches.
- R6: The negative pin of a phase is the inverse of its positive pin before polarity is applied. Polarity bit 0 (positive pins) and bit 1 (negative pins) set a pin to (active XOR bit), so a bit value of 1 makes that group active-low.
- R7: Enable bits [2:0] gate positive pins 0..2 and bits [5:3] gate negative pins 0..2. A disabled pin sits at its inactive level, which equals its polarity bit.
- R8: With enable bit 6 set, the toggle output inverts on every strobe at which the counter clears. With bit 6 clear, the toggle output is 0 and holds its state.
- R9: The prescaler source is bit k of a free-running 8-bit counter, where k is clock-select bits [2:0]. Clock-select bits [4:3] pick the edges: 0 counts on rising edges (one strobe every 2^(k+1) cycles), 1 on falling edges (the same rate), and 2 or 3 on both edges (one strobe every 2^k cycles).
- R10: When the run bit goes from 0 to 1, counting starts on the next strobe. When it is cleared, the counter, phases and toggle freeze at their current levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| pwm_p | output | 3 | Positive-phase PWM pins |
| pwm_n | output | 3 | Negative-phase PWM pins |
| tgl_out | output | 1 | Cycle toggle output |

## Verification
A register write is sampled at a rising edge and is visible on that edge's registers. A newly set run bit causes its first count on the following rising edge. Counter, phase and toggle updates all land on the edge of the strobe that causes them, and the pins follow combinationally. The bench drives inputs and samples outputs at the falling edge. After every rising edge it advances its own cycle model, so each comparison falls exactly half a cycle after the edge it checks. The prescaler ratios are checked by counting the cycles between two counter changes. The bench skips the first change after the clock select is written, so that the interval it measures is a full one.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_MODE = 4'd1;
  localparam logic [3:0] A_PER  = 4'd2;
  localparam logic [3:0] A_CMP0 = 4'd3;
  localparam logic [3:0] A_POL  = 4'd6;
  localparam logic [3:0] A_OEN  = 4'd7;
  localparam logic [3:0] A_CSEL = 4'd8;
  localparam logic [3:0] A_CNT  = 4'd9;
  localparam logic [3:0] MODE_RSYNC = 4'b1000;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/pwm3_prescale.sv
module pwm3_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [1:0]       edge_sel,
  output logic             strobe
);
  import pwm3_pkg::*;
  localparam int PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             src_q, src;

  always_comb begin
    pre_d = pre_q + 1'b1;
    src   = pre_q[div_sel];
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: strobe = src & ~src_q;
      EDGE_FALL: strobe = ~src & src_q;
      default:   strobe = src ^ src_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      src_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      src_q <= src;
    end
  end
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    wrap  = (count == period);
    cnt_d = count;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = wrap ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clr,
  input  logic          wrap,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] cmp,
  output logic          active
);
  logic hit, act_d;

  always_comb begin
    hit   = (count == cmp) && (cmp <= period);
    act_d = active;
    if (clr)       act_d = 1'b0;
    else if (step) begin
      if (hit)       act_d = 1'b1;
      else if (wrap) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= act_d;
  end
endmodule

// File: rtl/rsync_pwm3.sv
module rsync_pwm3 #(
  parameter int CNT_W = 16,
  parameter int NPH   = 3,
  parameter int SEL_W = 3,
  parameter int ADR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [NPH-1:0]   pwm_p,
  output logic [NPH-1:0]   pwm_n,
  output logic             tgl_out
);
  import pwm3_pkg::*;
  localparam int EN_W = 2 * NPH + 1;
  localparam int TEN  = 2 * NPH;

  logic                  run_q, run_d;
  logic [3:0]            mode_q, mode_d;
  logic [CNT_W-1:0]      per_q, per_d;
  logic [CNT_W-1:0]      cmp_q [NPH];
  logic [CNT_W-1:0]      cmp_d [NPH];
  logic [1:0]            pol_q, pol_d;
  logic [EN_W-1:0]       oen_q, oen_d;
  logic [SEL_W-1:0]      div_q, div_d;
  logic [1:0]            edg_q, edg_d;
  logic                  tog_q, tog_d;
  logic                  strobe, step, load, wrap, mode_ok;
  logic [NPH-1:0]        ph_act;

  always_comb begin
    run_d = run_q;  mode_d = mode_q; per_d = per_q; pol_d = pol_q;
    oen_d = oen_q;  div_d  = div_q;  edg_d = edg_q;
    for (int i = 0; i < NPH; i++) cmp_d[i] = cmp_q[i];
    if (wr_en) begin
      if (wr_addr == A_CTRL) run_d = wr_data[0];
      if (wr_addr == A_OEN)  oen_d = wr_data[EN_W-1:0];
      if (wr_addr == A_CSEL) begin
        div_d = wr_data[SEL_W-1:0];
        edg_d = wr_data[SEL_W+1:SEL_W];
      end
      if (!run_q) begin
        if (wr_addr == A_MODE) mode_d = wr_data[3:0];
        if (wr_addr == A_PER)  per_d  = wr_data;
        if (wr_addr == A_POL)  pol_d  = wr_data[1:0];
        for (int i = 0; i < NPH; i++)
          if (wr_addr == A_CMP0 + ADR_W'(i)) cmp_d[i] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; mode_q <= '0; per_q <= '0; pol_q <= '0;
      oen_q <= '0;   div_q  <= '0; edg_q <= '0;
      for (int i = 0; i < NPH; i++) cmp_q[i] <= '0;
    end else begin
      run_q <= run_d; mode_q <= mode_d; per_q <= per_d; pol_q <= pol_d;
      oen_q <= oen_d; div_q  <= div_d;  edg_q <= edg_d;
      for (int i = 0; i < NPH; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  assign load    = wr_en && (wr_addr == A_CNT) && !run_q;
  assign step    = run_q && strobe;
  assign mode_ok = (mode_q == MODE_RSYNC);

  pwm3_prescale #(.SEL_W(SEL_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .div_sel(div_q), .edge_sel(edg_q), .strobe(strobe)
  );

  pwm3_counter #(.CW(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load), .load_val(wr_data),
    .period(per_q), .count(count), .wrap(wrap)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    pwm3_phase #(.CW(CNT_W)) i_ph (
      .clk(clk), .rst_n(rst_n), .step(step), .clr(load), .wrap(wrap),
      .count(count), .period(per_q), .cmp(cmp_q[g]), .active(ph_act[g])
    );
    assign pwm_p[g] = (mode_ok & oen_q[g] & ph_act[g]) ^ pol_q[0];
    assign pwm_n[g] = (mode_ok & oen_q[NPH+g] & ~ph_act[g]) ^ pol_q[1];
  end

  always_comb begin
    tog_d = tog_q;
    if (load)                           tog_d = 1'b0;
    else if (step && wrap && oen_q[TEN]) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tgl_out = tog_q & oen_q[TEN];
endmodule

// File: rtl/pwm3_sva.sv
module pwm3_sva #(
  parameter int CNT_W = 16,
  parameter int NPH   = 3,
  parameter int ADR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             wr_en,
  input logic [ADR_W-1:0] wr_addr,
  input logic [CNT_W-1:0] per_q,
  input logic [3:0]       mode_q,
  input logic [1:0]       pol_q,
  input logic [CNT_W-1:0] count,
  input logic             wrap,
  input logic             step,
  input logic [NPH-1:0]   pwm_p,
  input logic [NPH-1:0]   pwm_n
);
  // R3
  period_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && wr_addr == 4'd2) |=> $stable(per_q));

  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && wr_addr == 4'd1) |=> $stable(mode_q));

  // R2
  wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap) |=> (count == '0));

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap) |=> (count == $past(count) + 1'b1));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(wr_en && wr_addr == 4'd9)) |=> $stable(count));

  // R4
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 4'b1000) |-> (pwm_p == {NPH{pol_q[0]}} && pwm_n == {NPH{pol_q[1]}}));
endmodule

bind rsync_pwm3 pwm3_sva #(.CNT_W(CNT_W), .NPH(NPH), .ADR_W(ADR_W)) i_pwm3_sva (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .per_q(per_q), .mode_q(mode_q), .pol_q(pol_q), .count(count), .wrap(wrap),
  .step(step), .pwm_p(pwm_p), .pwm_n(pwm_n)
);

// File: tb/test_rsync_pwm3.sv
module test_rsync_pwm3;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] count;
  logic [2:0]  pwm_p, pwm_n;
  logic        tgl_out;

  int checks = 0;
  int fails  = 0;

  // bench model of the programmed state
  logic        m_run;
  logic [3:0]  m_mode;
  logic [15:0] m_per, m_cnt;
  logic [15:0] m_cmp [3];
  logic [1:0]  m_pol;
  logic [6:0]  m_en;
  logic [2:0]  m_ph;
  logic        m_tog;

  rsync_pwm3 i_rsync_pwm3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pwm_p(pwm_p), .pwm_n(pwm_n), .tgl_out(tgl_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_p();
    for (int i = 0; i < 3; i++)
      exp_p[i] = ((m_mode == 4'b1000) & m_en[i] & m_ph[i]) ^ m_pol[0];
  endfunction

  function automatic logic [2:0] exp_n();
    for (int i = 0; i < 3; i++)
      exp_n[i] = ((m_mode == 4'b1000) & m_en[3+i] & ~m_ph[i]) ^ m_pol[1];
  endfunction

  task automatic model_edge(input bit w, input logic [3:0] a, input logic [15:0] d);
    logic was_run;
    was_run = m_run;
    if (was_run) begin
      for (int i = 0; i < 3; i++) begin
        if (m_cnt == m_cmp[i] && m_cmp[i] <= m_per) m_ph[i] = 1'b1;
        else if (m_cnt == m_per)                     m_ph[i] = 1'b0;
      end
      if (m_cnt == m_per && m_en[6]) m_tog = ~m_tog;
      m_cnt = (m_cnt == m_per) ? 16'd0 : m_cnt + 16'd1;
    end
    if (w) begin
      if (a == 4'd0) m_run = d[0];
      if (a == 4'd7) m_en  = d[6:0];
      if (!was_run) begin
        if (a == 4'd1) m_mode = d[3:0];
        if (a == 4'd2) m_per  = d;
        if (a == 4'd6) m_pol  = d[1:0];
        if (a >= 4'd3 && a <= 4'd5) m_cmp[a-4'd3] = d;
        if (a == 4'd9) begin m_cnt = d; m_ph = '0; m_tog = 1'b0; end
      end
    end
  endtask

  // entered and left at a falling edge
  task automatic cyc(input bit w, input logic [3:0] a, input logic [15:0] d);
    wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(w, a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " count"}, count, m_cnt);
    chk({tag, " pwm_p"}, {13'd0, pwm_p}, {13'd0, exp_p()});
    chk({tag, " pwm_n"}, {13'd0, pwm_n}, {13'd0, exp_n()});
    chk({tag, " toggle"}, {15'd0, tgl_out}, {15'd0, m_en[6] & m_tog});
  endtask

  task automatic run_cycles(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      cyc(1'b0, 4'd0, 16'd0);
      check_all(tag);
    end
  endtask

  task automatic gap(output int n);
    logic [15:0] c0;
    c0 = count; n = 0;
    while (count == c0 && n < 200) begin @(negedge clk); n++; end
    c0 = count; n = 0;
    while (count == c0 && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd7));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    m_run = 0; m_mode = 0; m_per = 0; m_cnt = 0; m_pol = 0; m_en = 0; m_ph = 0; m_tog = 0;
    for (int i = 0; i < 3; i++) m_cmp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 16'd0);
    chk("R1 pwm_p", {13'd0, pwm_p}, 16'd0);
    chk("R1 pwm_n", {13'd0, pwm_n}, 16'd0);
    chk("R1 toggle", {15'd0, tgl_out}, 16'd0);

    // directed: R2 R5 R6 R7 R8, compare equal to period and equal to zero
    wr(4'd8, 16'h0010);               // div 0, both edges
    wr(4'd1, 16'h0008);
    wr(4'd2, 16'd5);
    wr(4'd3, 16'd2); wr(4'd4, 16'd0); wr(4'd5, 16'd5);
    wr(4'd7, 16'h007f);
    wr(4'd9, 16'd0);
    check_all("R7");
    wr(4'd0, 16'd1);
    check_all("R10");
    run_cycles(20, "R5");

    // R3 writes while running are ignored
    wr(4'd2, 16'd3); check_all("R3");
    wr(4'd3, 16'd1); check_all("R3");
    wr(4'd1, 16'd0); check_all("R3");
    wr(4'd6, 16'd3); check_all("R3");
    wr(4'd9, 16'd4); check_all("R3");
    run_cycles(12, "R3");

    // R10 halting freezes everything
    wr(4'd0, 16'd0);
    run_cycles(6, "R10");

    // R4 other mode, with R6 inverted polarity
    wr(4'd1, 16'h0004);
    wr(4'd6, 16'd3);
    wr(4'd0, 16'd1);
    run_cycles(10, "R4");
    wr(4'd0, 16'd0);

    // random rounds
    for (int r = 0; r < 10; r++) begin
      logic [15:0] per;
      per = 16'($urandom_range(1, 15));
      wr(4'd0, 16'd0);
      wr(4'd1, ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 7)) : 16'h0008);
      wr(4'd2, per);
      for (int i = 0; i < 3; i++) wr(4'd3 + 4'(i), 16'($urandom_range(0, int'(per) + 2)));
      wr(4'd6, 16'($urandom_range(0, 3)));
      wr(4'd7, 16'($urandom_range(0, 127)));
      wr(4'd9, 16'd0);
      wr(4'd0, 16'd1);
      run_cycles(40, "R6");
      wr(4'd7, 16'($urandom_range(0, 127)));   // enables change while running
      check_all("R8");
      run_cycles(20, "R7");
    end

    // R9 prescaler ratios
    wr(4'd0, 16'd0);
    wr(4'd2, 16'd1000);
    wr(4'd9, 16'd0);
    wr(4'd8, 16'h0002);                // div 2, rising
    wr(4'd0, 16'd1);
    gap(n); chk("R9 div2 rising", 16'(n), 16'd8);
    wr(4'd8, 16'h0012);                // div 2, both
    gap(n); chk("R9 div2 both", 16'(n), 16'd4);
    wr(4'd8, 16'h000A);                // div 2, falling
    gap(n); chk("R9 div2 falling", 16'(n), 16'd8);
    wr(4'd8, 16'h0000);                // div 0, rising
    gap(n); chk("R9 div0 rising", 16'(n), 16'd2);
    wr(4'd8, 16'h001B);                // div 3, both (code 3)
    gap(n); chk("R9 div3 both", 16'(n), 16'd8);

    summary();
  end
endmodule